// File: doc/BRIEF.md
# Serial Fault Code Generator

This block reports a set of supervisor fault flags on one output pin. Each active fault is mapped to a fixed 16-bit code word. The code words of all faults that are present at once are ORed into a single word. That word is shifted out most significant bit first, one bit for each pulse of a bit-rate enable. When the last bit of a frame has gone out, the next enable pulse latches a fresh word from the current flags, so the pattern repeats for as long as the faults persist.

A receiver that knows the frame can decode every active fault from the one-hot middle byte of the word. When no fault is present the pin stays low. The flags are read only at frame boundaries. A flag that changes in the middle of a frame therefore cannot corrupt the frame being sent.

Top module: `fault_code_tx`

## Requirements
- R1: While `rstN` is low, and after its release until the first `bitTick`, `faultOut` is 0. The first `bitTick` after reset starts a new frame.
- R2: With `faultFlags` all zero at a frame boundary, the whole frame is sixteen 0 bits.
- R3: Any frame with at least one fault has 1111 in word bits 15..12 and 1010 in word bits 3..0.
- R4: A single active fault sets exactly one middle bit of the word. The mapping is: faultFlags[0] (battery undervoltage) sets bit 10, giving 16'hF40A. faultFlags[1] (battery overvoltage) sets bit 9, giving 16'hF20A. faultFlags[2] (supply undervoltage) sets bit 8, giving 16'hF10A. faultFlags[3] (supply overvoltage) sets bit 7, giving 16'hF08A. faultFlags[4] (temperature warning) sets bit 6, giving 16'hF04A. faultFlags[5] (overtemperature) sets bit 5, giving 16'hF02A.
- R5: With several faults active, the transmitted word is the bitwise OR of their single-fault codes.
- R6: Bits leave MSB first. `faultOut` changes only on a clock edge where `bitTick` is high, and holds its value otherwise.
- R7: A frame lasts exactly 16 `bitTick` pulses. With constant flags, every frame carries the same word.
- R8: The flags are sampled only on the `bitTick` that starts a frame. A flag change during a frame shows up in the next frame, not in the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | Bit-rate enable, one output bit per high cycle |
| faultFlags | input | 6 | Fault flags, bit mapping as in R4 |
| faultOut | output | 1 | Serial fault code, registered |

## Verification
Several properties are checked on every cycle by the assertions. The bit counter advances and wraps only on `bitTick`. The shift register holds, shifts by one, or loads the encoded word exactly as the control strobes direct. Every non-empty loaded word carries the preamble and trailer. The number of middle bits set equals the number of active flags. The bench's cycle-by-cycle reference model is needed for the rest: the exact code of each individual fault, the OR of several faults, the 16-tick frame repetition, and the rule that a flag change in mid-frame appears only in the following frame. These only show up as whole frames decoded at the pin.

// File: rtl/fault_code_pkg.sv
`timescale 1ns/1ps
package fault_code_pkg;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic load;   // latch a fresh code word (frame boundary)
    logic shift;  // advance to the next bit of the current frame
  } frame_strobe_t;

endpackage

// File: rtl/fault_code_enc.sv
`timescale 1ns/1ps
module fault_code_enc #(
  parameter int CODE_W    = 16,
  parameter int FAULT_CNT = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FAULT_CNT-1:0] faultFlags,
  output logic [CODE_W-1:0]    codeWord
);

  // First middle bit used by fault 0; lower faults move toward the LSB
  localparam int MID_HI = CODE_W - 6;
  localparam logic [CODE_W-1:0] FRAME_BITS = {4'hF, {(CODE_W-8){1'b0}}, 4'hA};

  logic [CODE_W-1:0] faultCode [FAULT_CNT];

  generate
    for (genvar g = 0; g < FAULT_CNT; g++) begin : g_code
      localparam logic [CODE_W-1:0] ONE_CODE = FRAME_BITS | (CODE_W'(1) << (MID_HI - g));
      assign faultCode[g] = faultFlags[g] ? ONE_CODE : '0;
    end
  endgenerate

  always_comb begin
    codeWord = '0;
    for (int i = 0; i < FAULT_CNT; i++) codeWord |= faultCode[i];
  end

  // R2: no active flag gives an all-zero word
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlags == '0) |-> (codeWord == '0));

  // R4/R5: each active flag contributes exactly one distinct middle bit
  p_mid_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(codeWord[CODE_W-5:4]) == $countones(faultFlags));

endmodule

// File: rtl/fault_code_ctrl.sv
`timescale 1ns/1ps
module fault_code_ctrl
  import fault_code_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitTick,
  output frame_strobe_t strb
);

  localparam int POS_W = $clog2(CODE_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CODE_W - 1);

  logic [POS_W-1:0] bitPos;

  // Reset parks the counter on the last position so the first tick loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bitPos <= LAST_POS;
    else if (bitTick) bitPos <= (bitPos == LAST_POS) ? '0 : bitPos + 1'b1;
  end

  always_comb begin
    strb.load  = bitTick && (bitPos == LAST_POS);
    strb.shift = bitTick && (bitPos != LAST_POS);
  end

  // R7: position advances by one per tick and wraps after CODE_W ticks
  p_pos_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> (($past(bitPos) == LAST_POS) ? (bitPos == '0)
                                             : (bitPos == $past(bitPos) + 1'b1)));

  // R6: no tick, no movement
  p_pos_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(bitPos));

endmodule

// File: rtl/fault_code_dp.sv
`timescale 1ns/1ps
module fault_code_dp
  import fault_code_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  frame_strobe_t     strb,
  input  logic [CODE_W-1:0] codeWord,
  output logic              faultOut
);

  logic [CODE_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shReg <= '0;
    else if (strb.load)  shReg <= codeWord;
    else if (strb.shift) shReg <= {shReg[CODE_W-2:0], 1'b0};
  end

  assign faultOut = shReg[CODE_W-1];

  // R6: register holds between ticks
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.shift) |=> $stable(shReg));

  // R6: MSB-first shift by exactly one position
  p_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (shReg == {$past(shReg[CODE_W-2:0]), 1'b0}));

  // R8: word is captured only at the frame boundary
  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (shReg == $past(codeWord)));

  // R3: every non-empty frame carries preamble and trailer
  p_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && (codeWord != '0)) |=>
      (shReg[CODE_W-1 -: 4] == 4'hF) && (shReg[3:0] == 4'hA));

endmodule

// File: rtl/fault_code_tx.sv
`timescale 1ns/1ps
module fault_code_tx
  import fault_code_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int FAULT_CNT = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic [FAULT_CNT-1:0] faultFlags,
  output logic                 faultOut
);

  frame_strobe_t     strb;
  logic [CODE_W-1:0] codeWord;

  fault_code_enc #(.CODE_W(CODE_W), .FAULT_CNT(FAULT_CNT)) u_enc (
    .clk        (clk),
    .rstN       (rstN),
    .faultFlags (faultFlags),
    .codeWord   (codeWord)
  );

  fault_code_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitTick (bitTick),
    .strb    (strb)
  );

  fault_code_dp #(.CODE_W(CODE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .codeWord (codeWord),
    .faultOut (faultOut)
  );

endmodule

// File: tb/fault_code_tx_tb.sv
`timescale 1ns/1ps
module fault_code_tx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic [5:0] faultFlags = '0;
  wire        faultOut;

  always #2 clk = ~clk;

  fault_code_tx u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .faultFlags(faultFlags), .faultOut(faultOut)
  );

  int    nTests = 0, nFail = 0;
  string curReq = "R1";
  bit    mq[$];
  int    frameStart = 0, tickCount = 0, cyc = 0, gap = 0;
  bit    tickOn = 0, randTick = 0, done = 0;

  function automatic logic [15:0] single(int i);
    case (i)
      0: return 16'hF40A;
      1: return 16'hF20A;
      2: return 16'hF10A;
      3: return 16'hF08A;
      4: return 16'hF04A;
      default: return 16'hF02A;
    endcase
  endfunction

  function automatic logic [15:0] expCode(logic [5:0] f);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 6; i++) if (f[i]) r |= single(i);
    return r;
  endfunction

  function automatic void check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  function automatic void finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endfunction

  // Behavioural reference: queue of bits still to be shown on the pin
  always @(posedge clk) begin : model
    logic [15:0] w;
    cyc++;
    if (!rstN) mq.delete();
    else if (bitTick) begin
      tickCount++;
      if (mq.size() > 0) void'(mq.pop_front());
      if (mq.size() == 0) begin
        w = expCode(faultFlags);
        for (int i = 15; i >= 0; i--) mq.push_back(w[i]);
        frameStart++;
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      finishRun();
    end
  end

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin : cmp
    logic e;
    if (rstN && !done) begin
      e = (mq.size() > 0) ? mq[0] : 1'b0;
      check(faultOut === e, curReq, {15'd0, faultOut}, {15'd0, e});
    end
  end

  // Bit-rate enable generator
  always @(negedge clk) begin
    if (!tickOn) bitTick = 1'b0;
    else if (randTick) bitTick = 1'($urandom_range(0, 1));
    else begin
      bitTick = (gap == 0);
      gap = (gap == 2) ? 0 : gap + 1;
    end
  end

  // Decode one whole frame from the pin; optionally change flags mid-frame
  task automatic capture(input logic [5:0] midFlags, input bit doSwap,
                         output logic [15:0] got);
    int s, t;
    s = frameStart;
    wait (frameStart != s);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      got[15-k] = faultOut;
      if (doSwap && k == 5) faultFlags = midFlags;
      t = tickCount;
      wait (tickCount != t);
    end
  endtask

  initial begin
    logic [15:0] g1, g2;
    logic [5:0]  fa, fb;

    // R1: reset state
    curReq = "R1";
    repeat (3) @(negedge clk);
    check(faultOut == 1'b0, "R1 in reset", {15'd0, faultOut}, 16'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(faultOut == 1'b0, "R1 before first tick", {15'd0, faultOut}, 16'h0);
    tickOn = 1;

    // R2: idle frames are all zero
    curReq = "R2";
    faultFlags = '0;
    capture('0, 0, g1);
    check(g1 == 16'h0, "R2 idle frame", g1, 16'h0);
    capture('0, 0, g1);
    check(g1 == 16'h0, "R2 idle frame repeat", g1, 16'h0);

    // R3/R4: each fault on its own
    curReq = "R4";
    for (int i = 0; i < 6; i++) begin
      faultFlags = 6'(1 << i);
      capture('0, 0, g1);
      check(g1 == single(i), "R4 single fault code", g1, single(i));
      check(g1[15:12] == 4'hF && g1[3:0] == 4'hA, "R3 preamble/trailer", g1, single(i));
    end

    // R5: coexisting faults
    curReq = "R5";
    foreach (fa[j]) fa[j] = 1'b0;
    for (int n = 0; n < 6; n++) begin
      case (n)
        0: fa = 6'b000011;
        1: fa = 6'b101010;
        2: fa = 6'b111111;
        default: fa = 6'($urandom_range(1, 63));
      endcase
      faultFlags = fa;
      capture('0, 0, g1);
      check(g1 == expCode(fa), "R5 ORed code", g1, expCode(fa));
      check(g1[15:12] == 4'hF && g1[3:0] == 4'hA, "R3 preamble/trailer ORed", g1, expCode(fa));
    end

    // R8: mid-frame change does not touch the frame in flight
    curReq = "R8";
    fa = 6'b000001;
    fb = 6'b100100;
    faultFlags = fa;
    capture(fb, 1, g1);
    check(g1 == expCode(fa), "R8 frame in flight", g1, expCode(fa));
    capture('0, 0, g2);
    check(g2 == expCode(fb), "R8 next frame", g2, expCode(fb));
    faultFlags = 6'b010000;
    capture(6'b000000, 1, g1);
    check(g1 == 16'hF04A, "R8 clear mid-frame", g1, 16'hF04A);
    capture('0, 0, g2);
    check(g2 == 16'h0, "R8 cleared next frame", g2, 16'h0);

    // R7: circulation with constant flags
    curReq = "R7";
    faultFlags = 6'b011000;
    capture('0, 0, g1);
    capture('0, 0, g2);
    check(g1 == g2 && g1 == expCode(6'b011000), "R7 repeated frame", g2, expCode(6'b011000));

    // R6: irregular tick spacing, pin must move only on ticks
    curReq = "R6";
    randTick = 1;
    for (int n = 0; n < 40; n++) begin
      faultFlags = 6'($urandom_range(0, 63));
      repeat ($urandom_range(5, 60)) @(negedge clk);
    end
    fa = 6'b100010;
    faultFlags = fa;
    capture('0, 0, g1);
    check(g1 == expCode(fa), "R6 MSB-first under random ticks", g1, expCode(fa));
    randTick = 0;

    // R1: reset in mid-frame returns the pin to 0
    curReq = "R1";
    faultFlags = 6'b111111;
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(faultOut == 1'b0, "R1 reset mid-frame", {15'd0, faultOut}, 16'h0);
    rstN = 1'b1;
    tickOn = 0;
    repeat (4) @(negedge clk);
    check(faultOut == 1'b0, "R1 idle after reset", {15'd0, faultOut}, 16'h0);
    tickOn = 1;
    capture('0, 0, g1);
    check(g1 == 16'hF7EA, "R1 first frame after reset", g1, 16'hF7EA);

    done = 1;
    finishRun();
  end

endmodule